// File: doc/BRIEF.md
# Automatic Handshake Flow Controller

This block runs the automatic request-to-send / clear-to-send handshake for one serial channel. It does not hold the receive FIFO or the shift registers. It observes the receive FIFO fill count and the trigger level that software has selected. From these it drives the active-low request-to-send pin with hysteresis, so the pin does not toggle on every character. The pin is driven high (stop sending) only once the fill reaches the trigger step above the selected one. It is driven low again only after the fill drains to the step below. While the pin is high the receiver keeps storing characters until the FIFO is full; the fill count simply continues to rise.

On the transmit side, the active-low clear-to-send pin passes through a synchronizer. The block then produces a transmit-permit level. The transmitter starts a new character only while the permit is high. A character that is already being shifted always finishes: the permit drops only at that character's end-of-stop-bit strobe. It drops at once if the transmitter is idle. A rising edge on the synchronized clear-to-send pin marks a flow-control request from the remote side. That edge can latch an interrupt status bit, which a host read of the status register clears.

Each direction has its own enable, and the two can be used independently. With automatic request-to-send off, the pin follows a host-written modem-control bit. With automatic clear-to-send off, transmission is always permitted.

Top module: `fc_flow_ctrl`

## Requirements
- R1: After reset, tx_permit is 1, flow_irq is 0, and the internal request-to-send hold-off state is clear.
- R2: With auto_rts_en = 0, rts_n equals the inverse of host_rts in the same cycle, whatever the rx_count value.
- R3: trig_sel selects the programmed trigger level: code 0 = 8, 1 = 16, 2 = 56, 3 = 60 characters.
- R4: With auto_rts_en = 1, rts_n goes to 1 in the cycle after rx_count reaches the hold-off level. The hold-off levels by code are 16, 56, 60 and 60 (codes 0 to 3).
- R5: With auto_rts_en = 1 and rts_n at 1, rts_n goes back to 0 in the cycle after rx_count falls to or below the release level. The release levels by code are 0, 8, 16 and 56 (codes 0 to 3). Between the two levels, rts_n keeps its previous value.
- R6: cts_n passes through a two-stage synchronizer. With auto_cts_en = 1 and tx_active = 0, tx_permit follows the inverse of cts_n three clock edges after the pin changes.
- R7: With auto_cts_en = 1, while tx_active = 1, tx_permit stays 1 after cts_n rises until the cycle after tx_char_done is pulsed. A character in progress is never cut off.
- R8: With auto_cts_en = 1, tx_permit returns to 1 three edges after cts_n returns to 0.
- R9: With auto_cts_en = 0, tx_permit stays 1 and flow_irq never sets, whatever cts_n does.
- R10: flow_irq sets three edges after a 0-to-1 change of cts_n, but only when auto_cts_en = 1 and cts_irq_en = 1. With cts_irq_en = 0 it stays 0.
- R11: A one-cycle status_rd pulse clears flow_irq on the next edge. If a new edge sets the bit in the same cycle as the clear, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_rts_en | input | 1 | Enable automatic request-to-send |
| auto_cts_en | input | 1 | Enable automatic clear-to-send gating |
| cts_irq_en | input | 1 | Enable the flow-control interrupt status |
| host_rts | input | 1 | Host modem-control bit; 1 drives rts_n low when automatic mode is off |
| trig_sel | input | 2 | Receive trigger level code |
| rx_count | input | 8 | Receive FIFO fill count |
| tx_active | input | 1 | Transmitter is shifting a character |
| tx_char_done | input | 1 | One-cycle strobe at the end of a character's stop bit |
| status_rd | input | 1 | Host read of the interrupt status; clears flow_irq |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| rts_n | output | 1 | Request-to-send pin, active low |
| tx_permit | output | 1 | Transmitter may start a new character |
| flow_irq | output | 1 | Flow-control interrupt status bit |

## Verification
The bench checks every trigger code at both edges of the hysteresis band. The count at one below the hold-off level and at one above the release level must leave rts_n unchanged. A design that used a single threshold, or swapped the levels between codes, would toggle the pin inside the band. The highest code, whose hold-off level equals its own trigger, is also checked, along with the lowest code, which releases only at an empty FIFO. The bench raises clear-to-send in the middle of a character and checks that the permit holds until the stop-bit strobe. A gate that did not track character boundaries would truncate the character. It also checks the set-versus-clear collision on the status bit, and that the disabled paths ignore the pin and the fill count.

// File: rtl/fc_flow_pkg.sv
package fc_flow_pkg;
  localparam int CNT_W = 8;

  typedef struct packed {
    logic [CNT_W-1:0] hold_lvl;
    logic [CNT_W-1:0] release_lvl;
  } fc_band_t;

  // Hysteresis band for each trigger code: hold-off is one step above, release one step below.
  function automatic fc_band_t band_of(input logic [1:0] code);
    fc_band_t b;
    unique case (code)
      2'd0: begin b.hold_lvl = CNT_W'(16); b.release_lvl = CNT_W'(0);  end
      2'd1: begin b.hold_lvl = CNT_W'(56); b.release_lvl = CNT_W'(8);  end
      2'd2: begin b.hold_lvl = CNT_W'(60); b.release_lvl = CNT_W'(16); end
      default: begin b.hold_lvl = CNT_W'(60); b.release_lvl = CNT_W'(56); end
    endcase
    return b;
  endfunction
endpackage

// File: rtl/fc_cts_sync.sv
module fc_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic hold_req,
  output logic req_rise
);
  localparam int MSB = STAGES - 1;

  logic [MSB:0] chain_q;
  logic         last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= pin_n;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[MSB-1:0], pin_n};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[MSB];

  assign hold_req = chain_q[MSB];
  assign req_rise = chain_q[MSB] & ~last_q;

  // R10: an edge pulse lasts exactly one cycle
  assert_rise_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_rise |=> !req_rise);
endmodule

// File: rtl/fc_rts_hyst.sv
module fc_rts_hyst
  import fc_flow_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] fill,
  output logic             holdoff
);
  fc_band_t band;
  logic     hold_q, hold_d;

  always_comb begin
    band   = band_of(trig_sel);
    hold_d = hold_q;
    if (!enable)                          hold_d = 1'b0;
    else if (!hold_q && fill >= band.hold_lvl)     hold_d = 1'b1;
    else if (hold_q && fill <= band.release_lvl)   hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;

  assign holdoff = hold_q;

  // R5: inside the band, the hold-off state does not move
  assert_band_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $stable(trig_sel) && fill > band.release_lvl && fill < band.hold_lvl)
      |=> $stable(hold_q));
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic hold_req,
  input  logic tx_active,
  input  logic tx_char_done,
  output logic permit
);
  logic permit_q, permit_d;

  always_comb begin
    if (!enable || !hold_req)                         permit_d = 1'b1;
    else if (permit_q && tx_active && !tx_char_done)  permit_d = 1'b1;
    else                                              permit_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) permit_q <= 1'b1;
    else        permit_q <= permit_d;

  assign permit = permit_q;

  // R7: a character being shifted keeps its permit until its stop bit ends
  assert_no_cut_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (permit_q && tx_active && !tx_char_done) |=> permit_q);
  // R9: with gating off the permit never drops
  assert_gate_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> permit_q);
endmodule

// File: rtl/fc_flow_ctrl.sv
module fc_flow_ctrl
  import fc_flow_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_rts_en,
  input  logic             auto_cts_en,
  input  logic             cts_irq_en,
  input  logic             host_rts,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             tx_active,
  input  logic             tx_char_done,
  input  logic             status_rd,
  input  logic             cts_n,
  output logic             rts_n,
  output logic             tx_permit,
  output logic             flow_irq
);
  logic hold_req, req_rise, holdoff, irq_q, irq_set;

  fc_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(cts_n),
    .hold_req(hold_req), .req_rise(req_rise)
  );

  fc_rts_hyst u_hyst (
    .clk(clk), .rst_n(rst_n), .enable(auto_rts_en),
    .trig_sel(trig_sel), .fill(rx_count), .holdoff(holdoff)
  );

  fc_tx_gate u_gate (
    .clk(clk), .rst_n(rst_n), .enable(auto_cts_en), .hold_req(hold_req),
    .tx_active(tx_active), .tx_char_done(tx_char_done), .permit(tx_permit)
  );

  assign irq_set = req_rise & auto_cts_en & cts_irq_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         irq_q <= 1'b0;
    else if (irq_set)   irq_q <= 1'b1;
    else if (status_rd) irq_q <= 1'b0;

  assign flow_irq = irq_q;
  assign rts_n    = auto_rts_en ? holdoff : ~host_rts;

  // R10: the status bit only rises when its enables were on
  assert_irq_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> ($past(cts_irq_en) && $past(auto_cts_en)));
  // R11: a read without a new edge clears the bit
  assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !req_rise) |=> !irq_q);
endmodule

// File: tb/fc_flow_ctrl_tb_top.sv
module fc_flow_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_rts_en = 0, auto_cts_en = 0, cts_irq_en = 0, host_rts = 0;
  logic [1:0] trig_sel = 0;
  logic [7:0] rx_count = 0;
  logic tx_active = 0, tx_char_done = 0, status_rd = 0, cts_n = 0;
  logic rts_n, tx_permit, flow_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fc_flow_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
    .cts_irq_en(cts_irq_en), .host_rts(host_rts), .trig_sel(trig_sel),
    .rx_count(rx_count), .tx_active(tx_active), .tx_char_done(tx_char_done),
    .status_rd(status_rd), .cts_n(cts_n), .rts_n(rts_n), .tx_permit(tx_permit),
    .flow_irq(flow_irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R1 permit", tx_permit, 1'b1);
    chk("R1 irq", flow_irq, 1'b0);
    auto_rts_en = 1; trig_sel = 0; rx_count = 8'd5; tick(1);
    chk("R1 holdoff clear", rts_n, 1'b0);
    auto_rts_en = 0; rx_count = 0; tick(1);
  endtask

  task automatic t_manual_rts;
    rx_count = 8'd100; host_rts = 1; #1;
    chk("R2 host on", rts_n, 1'b0);
    host_rts = 0; #1;
    chk("R2 host off", rts_n, 1'b1);
    tick(2);
    chk("R2 fill ignored", rts_n, 1'b1);
    rx_count = 0; tick(1);
  endtask

  task automatic t_band(input logic [1:0] code, input int hold, input int rel);
    auto_rts_en = 1; trig_sel = code; rx_count = 8'(rel); tick(2);
    chk("R3 start low", rts_n, 1'b0);
    rx_count = 8'(hold - 1); tick(1);
    chk("R4 below hold", rts_n, 1'b0);
    rx_count = 8'(hold); tick(1);
    chk("R4 at hold", rts_n, 1'b1);
    rx_count = 8'(rel + 1); tick(1);
    chk("R5 above release", rts_n, 1'b1);
    rx_count = 8'(rel); tick(1);
    chk("R5 at release", rts_n, 1'b0);
  endtask

  task automatic t_cts_idle;
    auto_cts_en = 1; tx_active = 0; cts_n = 1; tick(2);
    chk("R6 after two edges", tx_permit, 1'b1);
    tick(1);
    chk("R6 after three edges", tx_permit, 1'b0);
    cts_n = 0; tick(2);
    chk("R8 not yet", tx_permit, 1'b0);
    tick(1);
    chk("R8 resume", tx_permit, 1'b1);
  endtask

  task automatic t_cts_char;
    tx_active = 1; cts_n = 1; tick(6);
    chk("R7 held mid-char", tx_permit, 1'b1);
    tx_char_done = 1; tick(1); tx_char_done = 0; tx_active = 0;
    chk("R7 drop at stop bit", tx_permit, 1'b0);
    cts_n = 0; tick(3);
    chk("R8 resume after char", tx_permit, 1'b1);
  endtask

  task automatic t_irq;
    cts_irq_en = 1; cts_n = 1; tick(3);
    chk("R10 set", flow_irq, 1'b1);
    status_rd = 1; tick(1); status_rd = 0;
    chk("R11 cleared", flow_irq, 1'b0);
    cts_n = 0; tick(3);
    cts_n = 1; tick(2); status_rd = 1; tick(1); status_rd = 0;
    chk("R11 set wins", flow_irq, 1'b1);
    status_rd = 1; tick(1); status_rd = 0;
    cts_n = 0; tick(3);
    cts_irq_en = 0; cts_n = 1; tick(4);
    chk("R10 masked", flow_irq, 1'b0);
    cts_n = 0; tick(3);
  endtask

  task automatic t_cts_off;
    auto_cts_en = 0; cts_irq_en = 1; cts_n = 1; tick(5);
    chk("R9 permit", tx_permit, 1'b1);
    chk("R9 no irq", flow_irq, 1'b0);
    cts_n = 0; tick(3);
  endtask

  initial begin
    tick(2); rst_n = 1; tick(1);
    t_reset();
    t_manual_rts();
    t_band(2'd0, 16, 0);
    t_band(2'd1, 56, 8);
    t_band(2'd2, 60, 16);
    t_band(2'd3, 60, 56);
    t_cts_idle();
    t_cts_char();
    t_irq();
    t_cts_off();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule